// File: doc/BRIEF.md
# Handshaked Header Processing Stage

This block is one stage of a dataflow packet pipeline. It sits between a single upstream stage and a single downstream stage. It takes in one wide packet-header word, modifies it, and passes it on. Both links use the same three-step exchange. The receiving side raises a ready line. The sending side then presents the word together with a valid line. The receiving side then pulses an acknowledge line. Because of this exchange, the stage works next to neighbours whose latency it does not know.

Inside, a fixed control skeleton moves through a receive phase, an acknowledge phase, one or more processing phases and a send phase. The processing here is concrete. It reads the time-to-live byte of the header. If that byte is 2 or more, the stage decrements it. If it is 0 or 1, the stage leaves it unchanged and sets a drop flag instead. An optional memory port adds one further processing phase. In that phase the stage writes the new time-to-live and the drop flag to a fixed packet-relative address. A new packet is accepted only after the downstream side has acknowledged the current one.

Top module: `pe_element`

## Requirements
- R1: While rst_n is low, in_rdy, in_ack, out_vld and mem_we are all 0. In the first cycle after reset is released, in_rdy goes to 1.
- R2: The header is captured only at a clock edge where in_rdy and in_vld are both 1. At every other time in_data is ignored. At most one of in_rdy, in_ack, out_vld and mem_we is high in any cycle.
- R3: After a capture edge, in_ack is 1 for exactly one cycle and in_rdy is 0 during that cycle.
- R4: out_vld rises only after a cycle in which out_rdy was 1. Once high, out_vld stays high and out_data and out_drop stay stable until the clock edge at which out_ack is 1. In the cycle after that edge, out_vld is 0.
- R5: In the cycle after the edge at which out_vld and out_ack are both 1, in_rdy is 1. No new header is accepted between a capture and that acknowledge.
- R6: The time-to-live byte is in_data[TTL_LSB+7:TTL_LSB], with TTL_LSB defaulting to 64. If it is 2 or more, out_data carries that value minus 1 and out_drop is 0. If it is 0 or 1, the byte is passed on unchanged and out_drop is 1. All other bits of the header pass through unchanged.
- R7: With USE_MEM=1, mem_we is 1 for exactly one cycle per packet, between the input acknowledge and out_vld. In that cycle mem_addr equals MEM_ADDR (default 5). mem_wdata bits 7:0 hold the new time-to-live, bit 8 holds the drop flag, and the remaining bits are 0.
- R8: Every accepted header leaves exactly once, and headers leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | Upstream presents a header |
| in_data | input | HDR_W | Upstream header word |
| in_rdy | output | 1 | Stage can accept a header |
| in_ack | output | 1 | Stage acknowledges the captured header |
| out_rdy | input | 1 | Downstream can accept a header |
| out_ack | input | 1 | Downstream acknowledges receipt |
| out_vld | output | 1 | Stage presents a processed header |
| out_data | output | HDR_W | Processed header word |
| out_drop | output | 1 | Time-to-live expired; packet is marked for dropping |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | MEM_AW | Packet-relative memory address |
| mem_wdata | output | MEM_DW | Memory write data |

## Verification
The assertions check the link rules on every cycle:
- the handshake outputs are mutually exclusive;
- an acknowledge follows each capture as a one-cycle pulse;
- a valid is raised only after ready and is held with stable data until acknowledged;
- the input is released after the output acknowledge;
- the memory strobe is a single cycle.

Only the bench scenarios can show the data-side behaviour, which depends on sequences of packets:
- the time-to-live arithmetic over every byte value;
- the untouched remainder of the header;
- that bus contents outside a capture have no effect;
- the memory write contents;
- loss-free, duplicate-free, in-order delivery under random stalls on both sides.

// File: rtl/pe_pkg.sv
package pe_pkg;
  typedef enum logic [2:0] {
    ST_RECV = 3'd0,
    ST_ACK  = 3'd1,
    ST_USER = 3'd2,
    ST_MEMW = 3'd3,
    ST_WAIT = 3'd4,
    ST_SEND = 3'd5
  } pe_state_e;

  localparam int unsigned TTL_W = 8;
endpackage

// File: rtl/pe_ttl_unit.sv
module pe_ttl_unit
  import pe_pkg::*;
#(
  parameter int unsigned HDR_W   = 344,
  parameter int unsigned TTL_LSB = 64
) (
  input  logic [HDR_W-1:0] hdr_in,
  output logic [HDR_W-1:0] hdr_out,
  output logic             drop
);
  logic [TTL_W-1:0] ttl;

  always_comb begin
    ttl     = hdr_in[TTL_LSB +: TTL_W];
    hdr_out = hdr_in;
    drop    = (ttl < TTL_W'(2));
    if (!drop) begin
      hdr_out[TTL_LSB +: TTL_W] = ttl - TTL_W'(1);
    end
  end
endmodule

// File: rtl/pe_hdr_reg.sv
module pe_hdr_reg #(
  parameter int unsigned HDR_W = 344
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic             upd_en,
  input  logic [HDR_W-1:0] cap_data,
  input  logic [HDR_W-1:0] upd_data,
  input  logic             upd_drop,
  output logic [HDR_W-1:0] hdr_q,
  output logic             drop_q
);
  logic [HDR_W-1:0] hdr_d;
  logic             drop_d;

  always_comb begin
    hdr_d  = hdr_q;
    drop_d = drop_q;
    if (cap_en) begin
      hdr_d  = cap_data;
      drop_d = 1'b0;
    end else if (upd_en) begin
      hdr_d  = upd_data;
      drop_d = upd_drop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_q  <= '0;
      drop_q <= 1'b0;
    end else if (cap_en || upd_en) begin
      hdr_q  <= hdr_d;
      drop_q <= drop_d;
    end
  end
endmodule

// File: rtl/pe_ctrl.sv
module pe_ctrl
  import pe_pkg::*;
#(
  parameter bit USE_MEM = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_vld,
  input  logic out_rdy,
  input  logic out_ack,
  output logic cap_en,
  output logic upd_en,
  output logic in_rdy,
  output logic in_ack,
  output logic out_vld,
  output logic mem_we
);
  pe_state_e state_q, state_d;
  logic in_rdy_q, in_ack_q, out_vld_q, mem_we_q;

  assign cap_en = (state_q == ST_RECV) && in_rdy_q && in_vld;
  assign upd_en = (state_q == ST_USER);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RECV: if (cap_en) state_d = ST_ACK;
      ST_ACK:  state_d = ST_USER;
      ST_USER: state_d = USE_MEM ? ST_MEMW : ST_WAIT;
      ST_MEMW: state_d = ST_WAIT;
      ST_WAIT: if (out_rdy) state_d = ST_SEND;
      ST_SEND: if (out_ack) state_d = ST_RECV;
      default: state_d = ST_RECV;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RECV;
      in_rdy_q  <= 1'b0;
      in_ack_q  <= 1'b0;
      out_vld_q <= 1'b0;
      mem_we_q  <= 1'b0;
    end else begin
      state_q   <= state_d;
      in_rdy_q  <= (state_d == ST_RECV);
      in_ack_q  <= (state_d == ST_ACK);
      out_vld_q <= (state_d == ST_SEND);
      mem_we_q  <= (state_d == ST_MEMW);
    end
  end

  assign in_rdy  = in_rdy_q;
  assign in_ack  = in_ack_q;
  assign out_vld = out_vld_q;
  assign mem_we  = mem_we_q;

  assert_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_rdy, in_ack, out_vld, mem_we}));
  assert_cap_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rdy && in_vld) |=> (in_ack && !in_rdy));
  assert_ack_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |=> !in_ack);
  assert_vld_after_rdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_vld) |-> $past(out_rdy));
  assert_vld_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_ack) |=> out_vld);
  assert_vld_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_ack) |=> !out_vld);
  assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && out_ack) |=> in_rdy);
  assert_mem_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (!mem_we && !in_rdy));
endmodule

// File: rtl/pe_element.sv
module pe_element
  import pe_pkg::*;
#(
  parameter int unsigned HDR_W    = 344,
  parameter int unsigned TTL_LSB  = 64,
  parameter bit          USE_MEM  = 1'b1,
  parameter int unsigned MEM_AW   = 8,
  parameter int unsigned MEM_DW   = 16,
  parameter int unsigned MEM_ADDR = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [HDR_W-1:0]  in_data,
  output logic              in_rdy,
  output logic              in_ack,
  input  logic              out_rdy,
  input  logic              out_ack,
  output logic              out_vld,
  output logic [HDR_W-1:0]  out_data,
  output logic              out_drop,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [MEM_DW-1:0] mem_wdata
);
  localparam int unsigned PAD_W = MEM_DW - TTL_W - 1;

  logic             cap_en, upd_en, ctrl_mem_we;
  logic [HDR_W-1:0] hdr_q, hdr_new;
  logic             drop_q, drop_new;

  pe_ctrl #(.USE_MEM(USE_MEM)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .out_rdy(out_rdy),
    .out_ack(out_ack), .cap_en(cap_en), .upd_en(upd_en),
    .in_rdy(in_rdy), .in_ack(in_ack), .out_vld(out_vld),
    .mem_we(ctrl_mem_we)
  );

  pe_ttl_unit #(.HDR_W(HDR_W), .TTL_LSB(TTL_LSB)) u_ttl (
    .hdr_in(hdr_q), .hdr_out(hdr_new), .drop(drop_new)
  );

  pe_hdr_reg #(.HDR_W(HDR_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .upd_en(upd_en),
    .cap_data(in_data), .upd_data(hdr_new), .upd_drop(drop_new),
    .hdr_q(hdr_q), .drop_q(drop_q)
  );

  assign out_data = hdr_q;
  assign out_drop = drop_q;

  generate
    if (USE_MEM) begin : g_mem
      assign mem_we    = ctrl_mem_we;
      assign mem_addr  = ctrl_mem_we ? MEM_AW'(MEM_ADDR) : '0;
      assign mem_wdata = ctrl_mem_we ?
                         {{PAD_W{1'b0}}, drop_q, hdr_q[TTL_LSB +: TTL_W]} : '0;
    end else begin : g_nomem
      assign mem_we    = 1'b0;
      assign mem_addr  = '0;
      assign mem_wdata = '0;
    end
  endgenerate

  assert_out_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && !out_ack) |=> ($stable(out_data) && $stable(out_drop)));
  assert_hold_while_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_rdy && !in_ack && !$past(in_ack) && !mem_we && !$past(mem_we) && !out_vld)
      |=> $stable(out_data) || $past(in_ack));
endmodule

// File: tb/pe_element_tb.sv
`timescale 1ns/1ps
module pe_element_tb;
  localparam int unsigned HDR_W    = 344;
  localparam int unsigned TTL_LSB  = 64;
  localparam int unsigned MEM_AW   = 8;
  localparam int unsigned MEM_DW   = 16;
  localparam int unsigned MEM_ADDR = 5;
  localparam int          NPKT     = 300;

  logic              clk = 1'b0;
  logic              rst_n, in_vld, out_rdy, out_ack;
  logic [HDR_W-1:0]  in_data;
  logic              in_rdy, in_ack, out_vld, out_drop, mem_we;
  logic [HDR_W-1:0]  out_data;
  logic [MEM_AW-1:0] mem_addr;
  logic [MEM_DW-1:0] mem_wdata;

  always #2 clk = ~clk;

  pe_element #(.HDR_W(HDR_W), .TTL_LSB(TTL_LSB), .USE_MEM(1'b1),
               .MEM_AW(MEM_AW), .MEM_DW(MEM_DW), .MEM_ADDR(MEM_ADDR)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .in_rdy(in_rdy), .in_ack(in_ack), .out_rdy(out_rdy), .out_ack(out_ack),
    .out_vld(out_vld), .out_data(out_data), .out_drop(out_drop),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  int checks = 0;
  int fails  = 0;
  int rx_cnt = 0;
  int mem_cnt = 0;
  logic [HDR_W-1:0] expq[$];
  logic [HDR_W-1:0] last_pkt = '0;

  task automatic chk(input bit ok, input string tag,
                     input logic [HDR_W-1:0] act, input logic [HDR_W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [HDR_W-1:0] rnd_hdr();
    logic [HDR_W-1:0] v = '0;
    for (int k = 0; k < 11; k++) v = (v << 32) | HDR_W'($urandom);
    return v;
  endfunction

  function automatic logic [7:0] exp_ttl(input logic [HDR_W-1:0] p);
    logic [7:0] t = p[TTL_LSB +: 8];
    return (t >= 8'd2) ? t - 8'd1 : t;
  endfunction

  function automatic logic exp_drop(input logic [HDR_W-1:0] p);
    return p[TTL_LSB +: 8] < 8'd2;
  endfunction

  function automatic logic [HDR_W-1:0] exp_hdr(input logic [HDR_W-1:0] p);
    logic [HDR_W-1:0] e = p;
    e[TTL_LSB +: 8] = exp_ttl(p);
    return e;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  // Upstream side: presents headers only after ready, with garbage on the bus otherwise.
  initial begin
    logic [HDR_W-1:0] p;
    rst_n = 1'b0; in_vld = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    chk(!in_rdy && !in_ack && !out_vld && !mem_we, "R1 outputs low in reset",
        HDR_W'({in_rdy, in_ack, out_vld, mem_we}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_rdy, "R1 ready after reset release", HDR_W'(in_rdy), 1);
    for (int i = 0; i < NPKT; i++) begin
      p = rnd_hdr();
      if (i < 256) p[TTL_LSB +: 8] = i[7:0];
      repeat ($urandom % 4) begin
        @(negedge clk);
        in_data = rnd_hdr();
      end
      while (!in_rdy) begin
        @(negedge clk);
        in_data = rnd_hdr();
      end
      in_vld = 1'b1;
      in_data = p;
      expq.push_back(p);
      @(negedge clk);
      chk(in_ack, "R3 acknowledge follows capture", HDR_W'(in_ack), 1);
      chk(!in_rdy, "R3 ready low during acknowledge", HDR_W'(in_rdy), 0);
      last_pkt = p;
      in_vld = 1'b0;
      in_data = rnd_hdr();
      @(negedge clk);
      chk(!in_ack, "R3 acknowledge lasts one cycle", HDR_W'(in_ack), 0);
      in_data = rnd_hdr();
    end
  end

  // Downstream side: random readiness delay, random acknowledge delay.
  initial begin
    logic [HDR_W-1:0] e, first;
    out_rdy = 1'b0; out_ack = 1'b0;
    @(posedge rst_n);
    for (int j = 0; j < NPKT; j++) begin
      repeat ($urandom % 6) begin
        @(negedge clk);
        chk(!out_vld, "R4 no valid without ready", HDR_W'(out_vld), 0);
      end
      out_rdy = 1'b1;
      @(negedge clk);
      while (!out_vld) @(negedge clk);
      if (expq.size() == 0) begin
        chk(1'b0, "R8 output without accepted header", out_data, '0);
        e = '0;
      end else begin
        e = expq.pop_front();
      end
      chk(out_data == exp_hdr(e), "R6 R8 header contents and order", out_data, exp_hdr(e));
      chk(out_drop == exp_drop(e), "R6 drop flag", HDR_W'(out_drop), HDR_W'(exp_drop(e)));
      first = out_data;
      out_rdy = 1'b0;
      repeat ($urandom % 3) begin
        @(negedge clk);
        chk(out_vld && out_data == first, "R4 valid and data held until ack", out_data, first);
      end
      out_ack = 1'b1;
      @(negedge clk);
      out_ack = 1'b0;
      chk(!out_vld, "R4 valid low after ack", HDR_W'(out_vld), 0);
      chk(in_rdy, "R5 ready after output ack", HDR_W'(in_rdy), 1);
      rx_cnt++;
    end
    repeat (4) @(negedge clk);
    chk(rx_cnt == NPKT && expq.size() == 0, "R8 no loss or duplication",
        HDR_W'(rx_cnt), HDR_W'(NPKT));
    chk(mem_cnt == NPKT, "R7 one memory write per packet", HDR_W'(mem_cnt), HDR_W'(NPKT));
    summary();
    $finish;
  end

  // Memory port monitor.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mem_we) begin
        mem_cnt++;
        chk(mem_addr == MEM_ADDR[MEM_AW-1:0], "R7 memory address",
            HDR_W'(mem_addr), HDR_W'(MEM_ADDR));
        chk(mem_wdata == {7'd0, exp_drop(last_pkt), exp_ttl(last_pkt)}, "R7 memory data",
            HDR_W'(mem_wdata), HDR_W'({7'd0, exp_drop(last_pkt), exp_ttl(last_pkt)}));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired received=%0d expected=%0d", rx_cnt, NPKT);
    summary();
    $finish;
  end
endmodule